// File: doc/BRIEF.md
# Pseudorandom BPSK Quadrature Sample Generator

This block produces the digital baseband words for a quadrature upconverter in a pulse-compression radar transmitter. A carrier period stored as a table of sine and cosine points is read out one point per I/Q pair. An 8-stage maximal-length shift-register code switches the carrier between phase 0 and phase 180 degrees. Each code chip lasts exactly one carrier period of 100 points.

The inversion is not done by negating samples. At every chip edge the table read point jumps instead. A falling code edge (1 to 0) sends it to the half-period point. A rising edge (0 to 1) sends it back to point zero. The I word (cosine) and the Q word (sine) share one 14-bit output bus in alternating clock cycles, and a select flag marks which word is on the bus. All timing comes from the single sample clock, so no other control input exists.

Top module: `prbs_bpsk_iq_gen`

## Requirements
- R1: While rst_n is low, iq_data_o reads 0 and iq_sel_o reads 0. The first word after reset release is the I word for carrier point 0, and its code chip is 1.
- R2: After reset, iq_sel_o alternates every clock cycle. The value 0 marks an I (cosine) word and 1 marks a Q (sine) word. Every Q word is followed by an I word.
- R3: Within a chip, the carrier point advances by exactly one per I/Q pair (two clocks). It wraps from point 99 to point 0.
- R4: One code chip lasts exactly 100 I/Q pairs (200 clocks). Chip boundaries fall at pair indices that are multiples of 100, counted from reset release.
- R5: The chip sequence obeys a(n+8) = a(n) ^ a(n+4) ^ a(n+5) ^ a(n+6), which is the polynomial x^8+x^6+x^5+x^4+1. It is seeded with a(0..7) = 1,0,0,0,0,0,0,0 and repeats every 255 chips.
- R6: On a 1-to-0 chip edge, the first pair of the new chip reads carrier point 50, the half-period point.
- R7: On a 0-to-1 chip edge, the first pair of the new chip reads carrier point 0.
- R8: A word for carrier point m is round-to-nearest of 8191*cos(2*pi*m/100) for I and 8191*sin(2*pi*m/100) for Q, in 14-bit two's complement. Halves round away from zero.
- R9: The Q word of a pair uses the same carrier point as the I word that comes one clock before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one output word per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iq_data_o | output | 14 | Interleaved I/Q sample, two's complement |
| iq_sel_o | output | 1 | 0: I word on the bus, 1: Q word on the bus |

## Verification
The output word is registered, so the word that appears after rising edge e is read from the address state that existed before that edge. For that word the I/Q slot is (e-1) mod 2 and the pair index k is floor((e-1)/2). The bench's reference model computes that slot and index from the edge count alone. It then gets the carrier point from k mod 100 plus a 50-point offset when chip floor(k/100) of its own recurrence is 0. Every comparison is made on the falling edge after edge e. This sampling means a jump requested at a chip boundary is seen on the first word of the new chip, with zero extra latency beyond the output register. The run covers 257 chips, so the wrap of the 255-chip code is also compared.

// File: rtl/prbs_bpsk_pkg.sv
package prbs_bpsk_pkg;

   // Rounded amplitude*sin(2*pi*k/points), computed with a Taylor series
   function automatic int sine_code(input int k, input int points, input int amp);
      real x, term, acc, v;
      x = 6.283185307179586 * real'(k % points) / real'(points);
      if (x > 3.141592653589793) x = x - 6.283185307179586;
      term = x;
      acc  = x;
      for (int n = 1; n < 14; n++) begin
         term = -term * x * x / real'((2 * n) * (2 * n + 1));
         acc  = acc + term;
      end
      v = real'(amp) * acc;
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(-v + 0.5);
   endfunction

   // Table entry: region 0 holds sine points, region 1 holds cosine points
   function automatic int table_code(input int idx, input int points, input int amp);
      if (idx < points) return sine_code(idx, points, amp);
      else              return sine_code(idx - points + points / 4, points, amp);
   endfunction

endpackage

// File: rtl/prbs_bpsk_pace.sv
module prbs_bpsk_pace #(
   parameter int POINTS = 100
) (
   input  logic clk,
   input  logic rst_n,
   output logic iq_ph,
   output logic step_en,
   output logic chip_en
);
   localparam int CW = $clog2(POINTS);
   localparam logic [CW-1:0] LAST = CW'(POINTS - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iq_ph <= 1'b0;
         cnt   <= '0;
      end else begin
         iq_ph <= ~iq_ph;
         if (iq_ph) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign step_en = iq_ph;
   assign chip_en = iq_ph && (cnt == LAST);
endmodule

// File: rtl/prbs_bpsk_lfsr.sv
module prbs_bpsk_lfsr #(
   parameter int          LW   = 8,
   parameter logic [LW-1:0] TAPS = 8'b0111_0001,
   parameter logic [LW-1:0] SEED = 8'h01
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chip_en,
   output logic [LW-1:0] state,
   output logic          jump_low,
   output logic          jump_high
);
   logic fb;

   assign fb = ^(state & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state <= SEED;
      else if (chip_en) state <= {fb, state[LW-1:1]};
   end

   // state[0] is the current chip, state[1] becomes the next one
   assign jump_low  = chip_en &&  state[0] && !state[1];
   assign jump_high = chip_en && !state[0] &&  state[1];
endmodule

// File: rtl/prbs_bpsk_addr.sv
module prbs_bpsk_addr #(
   parameter int POINTS = 100,
   parameter int AW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_en,
   input  logic          jump_low,
   input  logic          jump_high,
   output logic [AW-1:0] sin_addr,
   output logic [AW-1:0] cos_addr
);
   logic [AW-1:0] addr [2];

   for (genvar r = 0; r < 2; r++) begin : g_region
      localparam logic [AW-1:0] FIRST = AW'(r * POINTS);
      localparam logic [AW-1:0] HALF  = AW'(r * POINTS + POINTS / 2);
      localparam logic [AW-1:0] LAST  = AW'(r * POINTS + POINTS - 1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) addr[r] <= FIRST;
         else if (step_en) begin
            if (jump_high)            addr[r] <= FIRST;
            else if (jump_low)        addr[r] <= HALF;
            else if (addr[r] == LAST) addr[r] <= FIRST;
            else                      addr[r] <= addr[r] + 1'b1;
         end
      end
   end

   assign sin_addr = addr[0];
   assign cos_addr = addr[1];
endmodule

// File: rtl/prbs_bpsk_rom.sv
module prbs_bpsk_rom
   import prbs_bpsk_pkg::*;
#(
   parameter int POINTS = 100,
   parameter int DW     = 14,
   parameter int AW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 2 * POINTS;
   localparam int AMP   = (1 << (DW - 1)) - 1;

   logic [DW-1:0] tbl [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_entry
      localparam logic [DW-1:0] VAL = DW'(table_code(k, POINTS, AMP));
      assign tbl[k] = VAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= tbl[rd_addr];
   end
endmodule

// File: rtl/prbs_bpsk_iq_gen.sv
module prbs_bpsk_iq_gen #(
   parameter int            POINTS = 100,
   parameter int            DW     = 14,
   parameter int            LW     = 8,
   parameter logic [LW-1:0] TAPS   = 8'b0111_0001,
   parameter logic [LW-1:0] SEED   = 8'h01
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [DW-1:0] iq_data_o,
   output logic          iq_sel_o
);
   localparam int AW = $clog2(2 * POINTS);

   if (POINTS % 4 != 0 || POINTS < 4) begin : g_bad_points
      $error("POINTS must be a positive multiple of 4");
   end
   if (SEED[0] != 1'b1) begin : g_bad_seed
      $error("SEED bit 0 (first chip) must be 1 to match the phase-0 reset address");
   end
   if (DW < 4) begin : g_bad_width
      $error("DW too small");
   end

   logic          iq_ph, step_en, chip_en;
   logic          jump_low, jump_high;
   logic [LW-1:0] lfsr_state;
   logic [AW-1:0] sin_addr, cos_addr;

   prbs_bpsk_pace #(.POINTS(POINTS)) u_pace (
      .clk(clk), .rst_n(rst_n), .iq_ph(iq_ph), .step_en(step_en), .chip_en(chip_en)
   );

   prbs_bpsk_lfsr #(.LW(LW), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .state(lfsr_state),
      .jump_low(jump_low), .jump_high(jump_high)
   );

   prbs_bpsk_addr #(.POINTS(POINTS), .AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .jump_low(jump_low),
      .jump_high(jump_high), .sin_addr(sin_addr), .cos_addr(cos_addr)
   );

   prbs_bpsk_rom #(.POINTS(POINTS), .DW(DW), .AW(AW)) u_rom (
      .clk(clk), .rst_n(rst_n), .rd_addr(iq_ph ? sin_addr : cos_addr), .rd_data(iq_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) iq_sel_o <= 1'b0;
      else        iq_sel_o <= iq_ph;
   end
endmodule

// File: rtl/prbs_bpsk_iq_chk.sv
module prbs_bpsk_iq_chk #(
   parameter int POINTS = 100,
   parameter int AW     = 8,
   parameter int LW     = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          iq_sel,
   input logic          step_en,
   input logic          jump_low,
   input logic          jump_high,
   input logic [LW-1:0] lfsr,
   input logic [AW-1:0] sin_a,
   input logic [AW-1:0] cos_a
);
   localparam logic [AW-1:0] P    = AW'(POINTS);
   localparam logic [AW-1:0] HALF = AW'(POINTS / 2);

   p_q_then_i_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iq_sel |=> !iq_sel);

   p_sin_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sin_a < P);

   p_hold_between_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(sin_a) && $stable(cos_a));

   p_pair_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cos_a == sin_a + P);

   p_no_zero_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);

   p_jump_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(jump_low && jump_high));

   p_fall_to_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
      jump_low |=> sin_a == HALF);

   p_rise_to_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      jump_high |=> sin_a == '0);
endmodule

bind prbs_bpsk_iq_gen prbs_bpsk_iq_chk #(.POINTS(POINTS), .AW(AW), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .iq_sel(iq_sel_o), .step_en(step_en),
   .jump_low(jump_low), .jump_high(jump_high), .lfsr(lfsr_state),
   .sin_a(sin_addr), .cos_a(cos_addr)
);

// File: tb/prbs_bpsk_iq_gen_tb.sv
module prbs_bpsk_iq_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NPTS       = 100;
   localparam int AMP        = 8191;
   localparam int NCHIPS     = 257;
   localparam int NEDGES     = NCHIPS * NPTS * 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] iq_data_o;
   logic        iq_sel_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int chip_seq [300];

   prbs_bpsk_iq_gen u_dut (.clk(clk), .rst_n(rst_n), .iq_data_o(iq_data_o), .iq_sel_o(iq_sel_o));

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic int rnd(input real v);
      if (v >= 0.0) return $rtoi(v + 0.5);
      else          return -$rtoi(-v + 0.5);
   endfunction

   function automatic logic [13:0] expect_word(input bit q, input int m);
      real ang;
      ang = 6.283185307179586 * real'(m) / real'(NPTS);
      if (q) return 14'(rnd(real'(AMP) * $sin(ang)));
      else   return 14'(rnd(real'(AMP) * $cos(ang)));
   endfunction

   task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp, input int edge_no);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s edge %0d: actual %0h expected %0h", req, edge_no, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 300000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R5 reference sequence: seed bits LSB first, then the recurrence
      for (int i = 0; i < 8; i++) chip_seq[i] = (i == 0) ? 1 : 0;
      for (int n = 0; n + 8 < 300; n++)
         chip_seq[n + 8] = chip_seq[n] ^ chip_seq[n + 4] ^ chip_seq[n + 5] ^ chip_seq[n + 6];

      repeat (3) @(negedge clk);
      check("R1", iq_data_o, 14'd0, 0);
      check("R1", {13'd0, iq_sel_o}, 14'd0, 0);
      rst_n = 1'b1;

      for (int e = 1; e <= NEDGES; e++) begin
         int k, j, m;
         bit q;
         string tag;
         @(negedge clk);
         q = ((e - 1) % 2) == 1;
         k = (e - 1) / 2;
         j = k / NPTS;
         m = ((k % NPTS) + (chip_seq[j % 255] == 1 ? 0 : NPTS / 2)) % NPTS;
         if (q)                                                    tag = "R9";
         else if (e == 1)                                          tag = "R1";
         else if (k % NPTS == 0 && j > 0 && chip_seq[(j - 1) % 255] == 1 && chip_seq[j % 255] == 0) tag = "R6";
         else if (k % NPTS == 0 && j > 0 && chip_seq[(j - 1) % 255] == 0 && chip_seq[j % 255] == 1) tag = "R7";
         else if (j >= 255)                                        tag = "R5";
         else if (k < NPTS)                                        tag = "R8";
         else if (k % NPTS == 0)                                   tag = "R4";
         else                                                      tag = "R3";
         check(tag, iq_data_o, expect_word(q, m), e);
         check("R2", {13'd0, iq_sel_o}, {13'd0, q}, e);
      end
      finish_run();
   end
endmodule